// File: doc/BRIEF.md
# Channel Byte FIFO with Block Interrupts

This block buffers the byte stream of a single 64 kbps voice or data channel in both directions. It sits between a frame receiver/transmitter and a host bus. Received bytes enter a receive FIFO. The host drains that FIFO in blocks whose size is set by a selectable threshold. The host fills a transmit FIFO, and the transmitter pulls bytes from it one at a time. The frame receiver supplies frame boundaries and the CRC verdict on sideband pins. The block only counts and buffers.

Interrupts are issued per block. A receive-ready flag rises each time a full threshold of a frame's bytes has arrived without the frame ending. A receive-end flag rises on the byte that closes the frame. The bytes the host has not yet been told about then number the frame length modulo the threshold, or a whole threshold when the length divides exactly. In that exact case only the end flag is raised. The frame length and the CRC verdict are latched for the host.

The flag register also reports receive overflow, transmit space becoming available, and transmit underrun. Reading the register clears it. A mask selects which flags drive the interrupt line. A 56 kbps mode forces the top bit of every octet to 1 and treats the channel as unframed.

Top module: `chan_fifo_irq`

## Requirements
- R1: The threshold select code 00 sets a threshold of THR_A bytes and code 10 sets THR_B bytes; reset selects code 00. A configuration write carrying code 01 or 11 leaves the threshold unchanged.
- R2: Flag bit 7 (receive-ready) is set on the edge that stores the byte that completes a run of threshold bytes since the last block announcement, unless that byte ends the frame.
- R3: Flag bit 6 (receive-end) is set on the edge that stores a byte marked frame end. At that point the bytes not yet announced number length mod threshold, or the threshold when the remainder is zero. No receive-ready flag is raised for that final block.
- R4: One cycle after a frame-end byte, {frm_len_hi, frm_len_lo} holds the frame length in bytes and frm_crc_err holds the inverse of rx_crc_ok.
- R5: A byte arriving at a full receive FIFO with no host read in the same cycle sets flag bit 5. The byte overwrites the oldest stored byte, and the level stays at DEPTH.
- R6: Flag bit 1 (transmit-ready) is set on the cycle the free transmit space rises from below the threshold to at least the threshold. It is not set at reset.
- R7: A transmit byte request while the transmit FIFO is empty and tx_active is high sets flag bit 0. The same request with tx_active low sets nothing.
- R8: irq_status resets to 00h, and bits 4..2 always read 0. An irq_rd clears all flags on the next edge, except flags set by an event in that same cycle, which remain set.
- R9: irq is high exactly when some flag is set whose bit is also set in the mask register. The mask register is written with cfg_mask on cfg_we and resets to E3h.
- R10: While 56 kbps mode is on, bit 7 of every stored receive byte and of tx_data reads 1. The frame-end input is then ignored: no receive-end flag is raised and the length registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_thr_sel | input | 2 | Threshold select code |
| cfg_sw56 | input | 1 | 56 kbps mode enable |
| cfg_mask | input | 8 | Interrupt mask, one bit per flag |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | Byte is the last of its frame |
| rx_crc_ok | input | 1 | CRC verdict, valid with rx_eof |
| host_rd | input | 1 | Host pops the receive FIFO head |
| host_rdata | output | 8 | Receive FIFO head byte |
| rx_level | output | CNT_W | Bytes held in the receive FIFO |
| host_wr | input | 1 | Host pushes a transmit byte |
| host_wdata | input | 8 | Transmit byte from the host |
| tx_req | input | 1 | Transmitter takes a byte |
| tx_active | input | 1 | Transmitter is inside a frame |
| tx_valid | output | 1 | Transmit FIFO holds a byte |
| tx_data | output | 8 | Transmit FIFO head byte |
| irq_rd | input | 1 | Read strobe that clears the flags |
| irq_status | output | 8 | Flag register |
| irq | output | 1 | Masked interrupt line |
| frm_len_hi | output | LEN_W-8 | Upper part of the last frame length |
| frm_len_lo | output | 8 | Lower 8 bits of the last frame length |
| frm_crc_err | output | 1 | CRC error of the last frame |

## Verification
The bench sweeps every frame length from 1 to 10 under both thresholds. The host drains each announced block. At frame end the bench checks that the residue equals length mod threshold, and that exact multiples give only the end flag. An off-by-one block counter would announce one byte early or late, or would raise both flags on exact multiples.

The bench overfills the receive FIFO and checks that the oldest byte is lost, not the newest. It drains the transmit FIFO byte by byte to check that the ready flag fires only on the crossing. Further checks cover the reserved and forbidden threshold codes, a read that coincides with a new event, and 56 kbps mode. A design that dropped the new byte, fired the ready flag on a level, lost the coinciding flag or honoured frame ends in 56 kbps mode would fail these checks.

// File: rtl/chan_fifo_pkg.sv
// Shared constants for the channel FIFO: flag bit positions and threshold codes.
package chan_fifo_pkg;
    localparam int FLAG_W   = 8;
    localparam int BIT_RRDY = 7;
    localparam int BIT_REND = 6;
    localparam int BIT_ROVF = 5;
    localparam int BIT_XRDY = 1;
    localparam int BIT_XUND = 0;

    typedef enum logic [1:0] {
        THR_SMALL = 2'b00,
        THR_RSVD  = 2'b01,
        THR_LARGE = 2'b10,
        THR_BAD   = 2'b11
    } thr_code_e;
endpackage

// File: rtl/byte_fifo.sv
// Circular byte FIFO with a level counter.
// Assumes pop on empty is ignored. When OVERWRITE is set, a push into a full
// FIFO without a pop replaces the oldest byte; otherwise that push is dropped.
module byte_fifo #(
    parameter int DEPTH     = 192,
    parameter int W         = 8,
    parameter bit OVERWRITE = 1'b0,
    parameter int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop, drop_old;

    assign full  = (level == CNT_W'(DEPTH));
    assign empty = (level == '0);
    assign dout  = mem[rd_ptr];

    generate
        if (OVERWRITE) begin : g_ovw
            assign drop_old = push & full & ~pop;
            assign do_push  = push;
        end else begin : g_drop
            assign drop_old = 1'b0;
            assign do_push  = push & (~full | pop);
        end
    endgenerate

    assign do_pop = (pop & ~empty) | drop_old;
    assign ovf    = push & full & ~pop;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Store the pushed byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Advance pointers and track the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (!do_push && do_pop) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/rx_block_ctl.sv
// Receive block accounting: counts bytes since the last block announcement,
// raises ready/end events, and latches frame length and CRC verdict.
// Assumes the threshold is nonzero; frame end is ignored in unframed mode.
module rx_block_ctl #(
    parameter int CNT_W = 8,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_in,
    input  logic             eof,
    input  logic             crc_ok,
    input  logic             unframed,
    input  logic [CNT_W-1:0] thr,
    output logic             rdy_evt,
    output logic             end_evt,
    output logic [LEN_W-1:0] len_q,
    output logic             crc_err_q
);
    logic [CNT_W-1:0] pend;
    logic [LEN_W-1:0] run;
    logic             frame_end;

    assign frame_end = byte_in & eof & ~unframed;
    assign end_evt   = frame_end;
    assign rdy_evt   = byte_in & ~frame_end & ((pend + 1'b1) >= thr);

    // Count unannounced bytes of the current block.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pend <= '0;
        else if (frame_end | rdy_evt) pend <= '0;
        else if (byte_in)             pend <= pend + 1'b1;
    end

    // Count frame length and latch it with the CRC verdict at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= '0;
            len_q     <= '0;
            crc_err_q <= 1'b0;
        end else if (frame_end) begin
            run       <= '0;
            len_q     <= run + 1'b1;
            crc_err_q <= ~crc_ok;
        end else if (byte_in) begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/irq_flags.sv
// Read-to-clear flag register with a mask; new sets win over a same-cycle clear.
module irq_flags #(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic              rd_clr,
    input  logic [FLAG_W-1:0] mask,
    output logic [FLAG_W-1:0] flags,
    output logic              irq
);
    // Accumulate events; a read clears all but the events of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      flags <= '0;
        else if (rd_clr) flags <= set_vec;
        else             flags <= flags | set_vec;
    end

    assign irq = |(flags & mask);
endmodule

// File: rtl/chan_fifo_irq.sv
// Channel FIFO pair with block-based interrupts for one byte channel.
// Receive side overwrites oldest data on overflow; transmit side drops host
// writes when full. Configuration is written through cfg_we.
module chan_fifo_irq
    import chan_fifo_pkg::*;
#(
    parameter int DEPTH = 192,
    parameter int THR_A = 64,
    parameter int THR_B = 96,
    parameter int LEN_W = 12,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_thr_sel,
    input  logic               cfg_sw56,
    input  logic [7:0]         cfg_mask,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    input  logic               rx_eof,
    input  logic               rx_crc_ok,
    input  logic               host_rd,
    output logic [7:0]         host_rdata,
    output logic [CNT_W-1:0]   rx_level,
    input  logic               host_wr,
    input  logic [7:0]         host_wdata,
    input  logic               tx_req,
    input  logic               tx_active,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    input  logic               irq_rd,
    output logic [7:0]         irq_status,
    output logic               irq,
    output logic [LEN_W-9:0]   frm_len_hi,
    output logic [7:0]         frm_len_lo,
    output logic               frm_crc_err
);
    localparam logic [7:0] MASK_RST = 8'hE3;
    localparam logic [CNT_W-1:0] THR_A_C = CNT_W'(THR_A);
    localparam logic [CNT_W-1:0] THR_B_C = CNT_W'(THR_B);

    thr_code_e        thr_sel_q;
    logic             sw56_q;
    logic [7:0]       mask_q;
    logic [CNT_W-1:0] thr;
    logic [7:0]       rx_byte, tx_head;
    logic [CNT_W-1:0] tx_level;
    logic             rx_full, rx_empty, rx_ovf;
    logic             tx_full, tx_empty, tx_ovf_unused;
    logic             space_ok, space_ok_q;
    logic             rdy_evt, end_evt;
    logic [LEN_W-1:0] len_q;
    logic [FLAG_W-1:0] set_vec;

    // Hold configuration; illegal threshold codes keep the old threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_sel_q <= THR_SMALL;
            sw56_q    <= 1'b0;
            mask_q    <= MASK_RST;
        end else if (cfg_we) begin
            sw56_q <= cfg_sw56;
            mask_q <= cfg_mask;
            if (cfg_thr_sel == THR_SMALL || cfg_thr_sel == THR_LARGE)
                thr_sel_q <= thr_code_e'(cfg_thr_sel);
        end
    end

    assign thr = (thr_sel_q == THR_LARGE) ? THR_B_C : THR_A_C;

    assign rx_byte = {rx_data[7] | sw56_q, rx_data[6:0]};

    byte_fifo #(.DEPTH(DEPTH), .W(8), .OVERWRITE(1'b1), .CNT_W(CNT_W)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_valid),
        .din   (rx_byte),
        .pop   (host_rd),
        .dout  (host_rdata),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty),
        .ovf   (rx_ovf)
    );

    byte_fifo #(.DEPTH(DEPTH), .W(8), .OVERWRITE(1'b0), .CNT_W(CNT_W)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (host_wr),
        .din   (host_wdata),
        .pop   (tx_req),
        .dout  (tx_head),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty),
        .ovf   (tx_ovf_unused)
    );

    assign tx_valid = ~tx_empty;
    assign tx_data  = {tx_head[7] | sw56_q, tx_head[6:0]};

    rx_block_ctl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_rx_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_in   (rx_valid),
        .eof       (rx_eof),
        .crc_ok    (rx_crc_ok),
        .unframed  (sw56_q),
        .thr       (thr),
        .rdy_evt   (rdy_evt),
        .end_evt   (end_evt),
        .len_q     (len_q),
        .crc_err_q (frm_crc_err)
    );

    assign space_ok = (CNT_W'(DEPTH) - tx_level) >= thr;

    // Remember whether transmit space was sufficient last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) space_ok_q <= 1'b1;
        else        space_ok_q <= space_ok;
    end

    // Map events to flag positions.
    always_comb begin
        set_vec           = '0;
        set_vec[BIT_RRDY] = rdy_evt;
        set_vec[BIT_REND] = end_evt;
        set_vec[BIT_ROVF] = rx_ovf;
        set_vec[BIT_XRDY] = space_ok & ~space_ok_q;
        set_vec[BIT_XUND] = tx_req & tx_empty & tx_active;
    end

    irq_flags #(.FLAG_W(FLAG_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .rd_clr  (irq_rd),
        .mask    (mask_q),
        .flags   (irq_status),
        .irq     (irq)
    );

    assign frm_len_hi = len_q[LEN_W-1:8];
    assign frm_len_lo = len_q[7:0];
endmodule

// File: rtl/chan_fifo_irq_chk.sv
// Temporal checks on the channel FIFO, attached to every instance by bind.
module chan_fifo_irq_chk #(
    parameter int DEPTH = 192,
    parameter int LEN_W = 12,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_eof,
    input logic             rx_crc_ok,
    input logic             host_rd,
    input logic [7:0]       host_rdata,
    input logic [CNT_W-1:0] rx_level,
    input logic             host_wr,
    input logic             tx_req,
    input logic             tx_active,
    input logic             tx_valid,
    input logic             cfg_we,
    input logic             irq_rd,
    input logic [7:0]       irq_status,
    input logic             frm_crc_err,
    input logic             sw56_q
);
    // R5: overflow flags and keeps the FIFO full
    p_ovf_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !host_rd && rx_level == CNT_W'(DEPTH)) |=> (irq_status[5] && rx_level == CNT_W'(DEPTH)));

    // R3: a framed end byte raises the end flag
    p_end_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_eof && !sw56_q) |=> irq_status[6]);

    // R4: CRC verdict latched at frame end
    p_crc_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_eof && !sw56_q) |=> (frm_crc_err == !$past(rx_crc_ok)));

    // R7: request on empty FIFO inside a frame flags underrun
    p_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_valid && tx_active) |=> irq_status[0]);

    // R8: a quiet read empties the flag register
    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rd && !rx_valid && !tx_req && !host_wr && !host_rd && !cfg_we) |=> (irq_status == 8'h00));

    // R10: in 56 kbps mode a byte entering an empty FIFO reads back with bit 7 set
    p_sw56_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw56_q && rx_valid && !host_rd && rx_level == '0) |=> host_rdata[7]);
endmodule

bind chan_fifo_irq chan_fifo_irq_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_eof      (rx_eof),
    .rx_crc_ok   (rx_crc_ok),
    .host_rd     (host_rd),
    .host_rdata  (host_rdata),
    .rx_level    (rx_level),
    .host_wr     (host_wr),
    .tx_req      (tx_req),
    .tx_active   (tx_active),
    .tx_valid    (tx_valid),
    .cfg_we      (cfg_we),
    .irq_rd      (irq_rd),
    .irq_status  (irq_status),
    .frm_crc_err (frm_crc_err),
    .sw56_q      (sw56_q)
);

// File: tb/chan_fifo_irq_tb.sv
`timescale 1ns/1ps
module chan_fifo_irq_tb;
    localparam int DEPTH = 12;
    localparam int THR_A = 4;
    localparam int THR_B = 6;
    localparam int LEN_W = 12;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_sw56 = 0;
    logic [1:0] cfg_thr_sel = 0;
    logic [7:0] cfg_mask = 8'hE3;
    logic rx_valid = 0, rx_eof = 0, rx_crc_ok = 0, host_rd = 0;
    logic [7:0] rx_data = 0, host_wdata = 0;
    logic host_wr = 0, tx_req = 0, tx_active = 0, irq_rd = 0;
    logic [7:0] host_rdata, tx_data, irq_status, frm_len_lo;
    logic [CNT_W-1:0] rx_level;
    logic [LEN_W-9:0] frm_len_hi;
    logic tx_valid, irq, frm_crc_err;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    chan_fifo_irq #(.DEPTH(DEPTH), .THR_A(THR_A), .THR_B(THR_B), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thr_sel(cfg_thr_sel),
        .cfg_sw56(cfg_sw56), .cfg_mask(cfg_mask), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .host_rd(host_rd), .host_rdata(host_rdata),
        .rx_level(rx_level), .host_wr(host_wr), .host_wdata(host_wdata), .tx_req(tx_req),
        .tx_active(tx_active), .tx_valid(tx_valid), .tx_data(tx_data), .irq_rd(irq_rd),
        .irq_status(irq_status), .irq(irq), .frm_len_hi(frm_len_hi), .frm_len_lo(frm_len_lo),
        .frm_crc_err(frm_crc_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic s56, input logic [7:0] m);
        @(negedge clk);
        cfg_we = 1; cfg_thr_sel = sel; cfg_sw56 = s56; cfg_mask = m;
        @(posedge clk); @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rx_byte(input logic [7:0] d, input logic e, input logic c);
        @(negedge clk);
        rx_valid = 1; rx_data = d; rx_eof = e; rx_crc_ok = c;
        @(posedge clk); @(negedge clk);
        rx_valid = 0; rx_eof = 0;
    endtask

    task automatic host_read(output logic [7:0] d);
        @(negedge clk);
        d = host_rdata; host_rd = 1;
        @(posedge clk); @(negedge clk);
        host_rd = 0;
    endtask

    task automatic read_flags(output logic [7:0] s);
        @(negedge clk);
        s = irq_status; irq_rd = 1;
        @(posedge clk); @(negedge clk);
        irq_rd = 0;
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        host_wr = 1; host_wdata = d;
        @(posedge clk); @(negedge clk);
        host_wr = 0;
    endtask

    task automatic tx_pop(output logic [7:0] d);
        @(negedge clk);
        d = tx_data; tx_req = 1;
        @(posedge clk); @(negedge clk);
        tx_req = 0;
    endtask

    function automatic logic [7:0] pat(input int len, input int idx);
        return 8'((len * 9 + idx * 5) & 8'h7F);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [7:0] st, d;
        int rd_i, exp_res;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check("R8 reset flags", irq_status, 0);
        check("R9 reset irq", irq, 0);
        check("R5 reset rx level", rx_level, 0);

        // R1 R2 R3 R4: sweep both thresholds and frame lengths 1..10
        for (int t_i = 0; t_i < 2; t_i++) begin
            int thr;
            thr = (t_i == 0) ? THR_A : THR_B;
            cfg((t_i == 0) ? 2'b00 : 2'b10, 1'b0, 8'hE3);
            for (int len = 1; len <= 10; len++) begin
                rd_i = 1;
                for (int i = 1; i <= len; i++) begin
                    rx_byte(pat(len, i), i == len, len[0]);
                    read_flags(st);
                    if (i < len) begin
                        check("R1 R2 ready flag", st[7], (i % thr) == 0);
                        check("R3 no early end", st[6], 0);
                        if (st[7]) begin
                            for (int k = 0; k < thr; k++) begin
                                host_read(d);
                                check("R2 block data", d, pat(len, rd_i));
                                rd_i++;
                            end
                        end
                    end else begin
                        exp_res = (len % thr == 0) ? thr : len % thr;
                        check("R3 end flag", st[6], 1);
                        check("R3 no ready on final block", st[7], 0);
                        check("R3 residue", rx_level, exp_res);
                        check("R4 length", {frm_len_hi, frm_len_lo}, len);
                        check("R4 crc err", frm_crc_err, !len[0]);
                        for (int k = 0; k < exp_res; k++) begin
                            host_read(d);
                            check("R3 tail data", d, pat(len, rd_i));
                            rd_i++;
                        end
                    end
                end
            end
        end

        // R1: illegal codes keep the large threshold
        cfg(2'b01, 1'b0, 8'hE3);
        cfg(2'b11, 1'b0, 8'hE3);
        for (int i = 1; i <= 5; i++) begin
            rx_byte(pat(5, i), i == 5, 1'b1);
            read_flags(st);
            if (i == 4) check("R1 illegal code ignored", st[7], 0);
        end
        check("R1 residue with kept threshold", rx_level, 5);
        for (int k = 0; k < 5; k++) host_read(d);

        // R5: overflow overwrites the oldest byte
        cfg(2'b00, 1'b0, 8'hE3);
        read_flags(st);
        for (int i = 0; i < 13; i++) rx_byte(8'h20 + 8'(i), 1'b0, 1'b1);
        read_flags(st);
        check("R5 overflow flag", st[5], 1);
        check("R5 level stays full", rx_level, DEPTH);
        for (int k = 1; k <= 12; k++) begin
            host_read(d);
            check("R5 oldest dropped", d, 8'h20 + 8'(k));
        end
        rx_byte(8'h00, 1'b1, 1'b1);
        read_flags(st);
        host_read(d);

        // R8: new event in the same cycle as a clearing read survives
        @(negedge clk);
        rx_valid = 1; rx_data = 8'h11; rx_eof = 1; rx_crc_ok = 1; irq_rd = 1;
        @(posedge clk); @(negedge clk);
        rx_valid = 0; rx_eof = 0; irq_rd = 0;
        check("R8 set wins over clear", irq_status, 8'h40);
        read_flags(st);
        check("R8 cleared after read", irq_status, 0);
        host_read(d);

        // R7 R9: underrun, masking
        cfg(2'b00, 1'b0, 8'h40);
        @(negedge clk); tx_active = 1; tx_req = 1;
        @(posedge clk); @(negedge clk); tx_req = 0;
        check("R7 underrun flag", irq_status[0], 1);
        check("R9 masked off", irq, 0);
        cfg(2'b00, 1'b0, 8'h01);
        check("R9 mask enabled", irq, 1);
        read_flags(st);
        check("R9 irq drops after read", irq, 0);
        @(negedge clk); tx_active = 0; tx_req = 1;
        @(posedge clk); @(negedge clk); tx_req = 0;
        check("R7 no underrun outside frame", irq_status, 0);
        cfg(2'b00, 1'b0, 8'hE3);

        // R6: transmit-ready fires only when free space crosses the threshold
        for (int i = 0; i < DEPTH; i++) host_write(8'h30 + 8'(i));
        read_flags(st);
        check("R6 no ready while filling", st[1], 0);
        for (int k = 1; k <= DEPTH; k++) begin
            tx_pop(d);
            check("R6 tx order", d, 8'h30 + 8'(k - 1));
            read_flags(st);
            check("R6 ready on crossing", st[1], k == THR_A);
        end
        check("R6 tx empty", tx_valid, 0);

        // R10: 56 kbps mode forces bit 7 and ignores frame end
        cfg(2'b00, 1'b1, 8'hE3);
        rx_byte(8'h12, 1'b1, 1'b0);
        read_flags(st);
        check("R10 no end flag", st[6], 0);
        check("R10 length unchanged", {frm_len_hi, frm_len_lo}, 1);
        host_read(d);
        check("R10 rx bit7 forced", d, 8'h92);
        host_write(8'h05);
        check("R10 tx bit7 forced", tx_data, 8'h85);
        tx_pop(d);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule